// File: doc/BRIEF.md
# Sliced Lookup-Table Trigger Evaluator

This block decides, once per time slot, whether a programmable Boolean condition across several detector channels was met in any of the slot's fine time slices. Each channel delivers a bitmap with one bit per slice. The block regroups those bitmaps into one word per slice, holding one bit per channel. That word is the address into a truth table which holds the trigger condition. Every slice has its own copy of the table, so all slices are evaluated in the same clock. The slot is accepted when any slice answers true.

The table is loaded at run time through a single write port. Each write goes to every slice copy at once, so the copies stay identical. Loading does not touch the evaluation path. A new slot can enter on every clock, and each result appears after a fixed three-cycle latency.

Top module: `lut_trigger_eval`

## Requirements
- R1: Input bit `slot_bits[c*N_SLICE + s]` is the state of channel `c` in slice `s`. The table address for slice `s` is the word whose bit `c` is that channel's bit, with channel 0 as the least significant bit.
- R2: For a valid slot, `slice_hits[s]` equals the table entry at slice `s`'s address.
- R3: A write on the table port (`tbl_we`, `tbl_addr`, `tbl_data`) updates the entry in all slice copies. It applies to a slot presented in the same cycle as the write or in any later cycle. It does not apply to a slot presented in an earlier cycle.
- R4: `slot_accept` is the OR of all `slice_hits` of the same result.
- R5: `slot_valid_out` rises exactly 3 cycles after the cycle in which `slot_valid` was high. Slots presented back to back give results on back-to-back cycles, in order, and table writes do not disturb this.
- R6: When a result is not valid, `slot_accept` and all `slice_hits` are 0, even if the table entry for address 0 is 1.
- R7: Synchronous active-low reset clears every table entry to 0 and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | A slot's bitmaps are present this cycle |
| slot_bits | input | N_CH*N_SLICE | Per-channel slice bitmaps, bit c*N_SLICE+s |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | N_CH | Table entry written, one bit per channel |
| tbl_data | input | 1 | Trigger response stored at that entry |
| slot_valid_out | output | 1 | Result for a slot is valid |
| slot_accept | output | 1 | Slot accepted |
| slice_hits | output | N_SLICE | Per-slice table responses |

## Verification
The hardest case to reach from the ports is the exact cycle boundary at which a table write begins to affect results. A write must reach a slot presented in the same cycle, but it must miss a slot presented one cycle earlier that is still in flight. The stimulus places a slot and a write of the entry that slot will address in the same cycle, in the cycle after, and in the cycle before. The scoreboard's model applies each write in program order, so each of these cases predicts a different result. A second situation is an idle cycle while the table answers true for the all-zero address. Only the gating of invalid slots keeps the hits low there, and the bench sets this up deliberately.

// File: rtl/trg_eval_pkg.sv
// Package: default sizing and pipeline depth for the sliced trigger evaluator.
// Assumes: the number of slices is a power of two set by a slice-index width.
package trg_eval_pkg;
    localparam int unsigned DEF_N_CH       = 8;
    localparam int unsigned DEF_SLICE_BITS = 4;
    localparam int unsigned PIPE_LAT       = 3;
endpackage

// File: rtl/slice_regroup.sv
// Module: slice_regroup
// Registers a slot and transposes channel-major bitmaps into slice-major
// words (one bit per channel in each word). An invalid slot yields all-zero words.
// Assumes: input bit c*N_SLICE+s is channel c in slice s.
module slice_regroup #(
    parameter int unsigned N_CH    = 8,
    parameter int unsigned N_SLICE = 16,
    localparam int unsigned NBITS  = N_CH * N_SLICE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [NBITS-1:0] in_bits,
    output logic             words_valid,
    output logic [NBITS-1:0] words
);
    logic [NBITS-1:0] transposed;

    // Transpose: output bit s*N_CH+c takes input bit c*N_SLICE+s.
    always_comb begin
        for (int s = 0; s < N_SLICE; s++) begin
            for (int c = 0; c < N_CH; c++) begin
                transposed[s*N_CH + c] = in_bits[c*N_SLICE + s];
            end
        end
    end

    // Stage 1 register, with words zeroed on slots that are not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_valid <= 1'b0;
            words       <= '0;
        end else begin
            words_valid <= in_valid;
            words       <= in_valid ? transposed : '0;
        end
    end

    // R6: an idle cycle leaves no residue in the slice words.
    a_r6_idle_words_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (words == '0));
endmodule

// File: rtl/slice_lut.sv
// Module: slice_lut
// One copy of the trigger truth table for one slice. The table is written
// through a shared port and read with the slice word; the result is registered.
// Assumes: every copy gets the same write stream, so all copies stay identical.
module slice_lut #(
    parameter int unsigned N_CH  = 8,
    localparam int unsigned DEPTH = 1 << N_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [N_CH-1:0] wr_addr,
    input  logic            wr_data,
    input  logic [N_CH-1:0] word,
    output logic            hit
);
    logic [DEPTH-1:0] table_q;

    // Table storage: cleared on reset, then written one entry at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_q <= '0;
        end else if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    // Lookup: registers the response addressed by this slice's word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= table_q[word];
        end
    end

    // R3: a write lands in this copy on the next edge.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (table_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/accept_reduce.sv
// Module: accept_reduce
// Final stage: gates the per-slice responses with the slot valid, ORs them
// into the accept flag and registers both with the output strobe.
// Assumes: hits and valid arrive aligned from the lookup stage.
module accept_reduce #(
    parameter int unsigned N_SLICE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [N_SLICE-1:0] in_hits,
    output logic               out_valid,
    output logic               out_accept,
    output logic [N_SLICE-1:0] out_hits
);
    // Output register: valid strobe, gated hits and their OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
            out_hits   <= '0;
        end else begin
            out_valid  <= in_valid;
            out_accept <= in_valid & (|in_hits);
            out_hits   <= in_valid ? in_hits : '0;
        end
    end

    // R4: the flag agrees with the slice responses that are presented.
    a_r4_accept_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept == (|out_hits));
    // R5: the strobe follows the lookup-stage valid by one cycle.
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6: nothing is reported outside a valid result.
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_accept && out_hits == '0));
    // R7: reset leaves the outputs low.
    a_r7_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_accept));
endmodule

// File: rtl/lut_trigger_eval.sv
// Module: lut_trigger_eval (top)
// Evaluates a programmable channel condition in every slice of a time slot in
// parallel (one truth-table copy per slice) and flags the slot when any slice
// matches. Latency is fixed at three cycles, with one slot accepted per clock.
// Assumes: table writes go to every copy at once; there is no read-back path.
module lut_trigger_eval #(
    parameter int unsigned N_CH       = trg_eval_pkg::DEF_N_CH,
    parameter int unsigned SLICE_BITS = trg_eval_pkg::DEF_SLICE_BITS,
    localparam int unsigned N_SLICE   = 1 << SLICE_BITS,
    localparam int unsigned NBITS     = N_CH * N_SLICE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_valid,
    input  logic [NBITS-1:0]   slot_bits,
    input  logic               tbl_we,
    input  logic [N_CH-1:0]    tbl_addr,
    input  logic               tbl_data,
    output logic               slot_valid_out,
    output logic               slot_accept,
    output logic [N_SLICE-1:0] slice_hits
);
    logic               s1_valid;
    logic [NBITS-1:0]   s1_words;
    logic               s2_valid;
    logic [N_SLICE-1:0] s2_hits;

    slice_regroup #(.N_CH(N_CH), .N_SLICE(N_SLICE)) u_regroup (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (slot_valid),
        .in_bits    (slot_bits),
        .words_valid(s1_valid),
        .words      (s1_words)
    );

    // Stage 2 valid: follows the lookup registers inside each slice copy.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= s1_valid;
    end

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        slice_lut #(.N_CH(N_CH)) u_lut (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (tbl_we),
            .wr_addr(tbl_addr),
            .wr_data(tbl_data),
            .word   (s1_words[s*N_CH +: N_CH]),
            .hit    (s2_hits[s])
        );
    end

    accept_reduce #(.N_SLICE(N_SLICE)) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s2_valid),
        .in_hits   (s2_hits),
        .out_valid (slot_valid_out),
        .out_accept(slot_accept),
        .out_hits  (slice_hits)
    );

    // R5: stage valids chain without gaps from input to output.
    a_r5_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> s2_valid);
    // R2: a lookup stage idle slot produces no reported hit.
    a_r2_hits_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_hits != '0) |-> slot_valid_out);
endmodule

// File: tb/tb_lut_trigger_eval.sv
module tb_lut_trigger_eval;
    localparam int NC  = 8;
    localparam int NS  = 16;
    localparam int NB  = NC * NS;
    localparam int LAT = 3;

    typedef struct {
        int              cyc;
        logic [NS-1:0]   hits;
        logic            acc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0;
    logic [NB-1:0] slot_bits = '0;
    logic tbl_we = 1'b0;
    logic [NC-1:0] tbl_addr = '0;
    logic tbl_data = 1'b0;
    logic slot_valid_out, slot_accept;
    logic [NS-1:0] slice_hits;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0, mon_on = 0;
    logic [(1<<NC)-1:0] ref_tbl = '0;
    exp_t q[$];

    lut_trigger_eval dut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_bits(slot_bits),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .slot_valid_out(slot_valid_out), .slot_accept(slot_accept),
        .slice_hits(slice_hits)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of inputs; a same-cycle write applies to the slot (R3).
    task automatic step(input bit v, input logic [NB-1:0] bits,
                        input bit we, input logic [NC-1:0] a, input bit d);
        exp_t e;
        @(negedge clk);
        slot_valid = v; slot_bits = bits;
        tbl_we = we; tbl_addr = a; tbl_data = d;
        if (we) ref_tbl[a] = d;
        if (v) begin
            e.cyc = cyc + LAT;
            e.acc = 1'b0;
            for (int s = 0; s < NS; s++) begin
                logic [NC-1:0] w;
                for (int c = 0; c < NC; c++) w[c] = bits[c*NS + s];
                e.hits[s] = ref_tbl[w];
                e.acc = e.acc | e.hits[s];
            end
            q.push_back(e);
        end
    endtask

    task automatic wr(input logic [NC-1:0] a, input bit d);
        step(1'b0, '0, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    function automatic logic [NB-1:0] chbit(input int c, input int s);
        logic [NB-1:0] b = '0;
        b[c*NS + s] = 1'b1;
        return b;
    endfunction

    // Monitor: pops the scoreboard as results emerge.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (slot_valid_out) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5", "unexpected valid", 64'(cyc), 64'hffff);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.cyc, "R5", "result cycle", 64'(cyc), 64'(e.cyc));
                    check(slice_hits == e.hits, "R1,R2", "slice hits",
                          64'(slice_hits), 64'(e.hits));
                    check(slot_accept == e.acc, "R4", "accept",
                          64'(slot_accept), 64'(e.acc));
                end
            end else begin
                check(!slot_accept && slice_hits == '0, "R6", "idle outputs",
                      {slice_hits, 47'd0, slot_accept}, 64'd0);
                if (q.size() != 0)
                    check(q[0].cyc > cyc, "R5", "missing result", 64'(cyc), 64'(q[0].cyc));
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "ALL", "watchdog", 64'(cyc), 64'd0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R7: outputs low while in reset.
        check(!slot_valid_out && !slot_accept && slice_hits == '0, "R7", "reset outputs",
              {slice_hits, 47'd0, slot_accept}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R7: table cleared, so even all-ones and all-zero slots miss.
        step(1'b1, '1, 1'b0, '0, 1'b0);
        step(1'b1, '0, 1'b0, '0, 1'b0);
        idle(4);
        // R1: condition "channel 2 alone"; boundary slices 0 and 15.
        wr(8'h04, 1'b1);
        step(1'b1, chbit(2, 0) | chbit(2, NS-1), 1'b0, '0, 1'b0);
        step(1'b1, chbit(2, 6) | chbit(3, 6), 1'b0, '0, 1'b0);
        step(1'b1, chbit(3, 9), 1'b0, '0, 1'b0);
        // R6: entry 0 true, idle cycles must stay quiet; a valid empty slot hits all.
        wr(8'h00, 1'b1);
        idle(5);
        step(1'b1, '0, 1'b0, '0, 1'b0);
        wr(8'h00, 1'b0);
        idle(4);
        // R3: write timing relative to the slot that uses the entry.
        step(1'b1, chbit(0, 3), 1'b1, 8'h01, 1'b1);   // same cycle: applies
        step(1'b1, chbit(0, 3), 1'b1, 8'h01, 1'b0);   // same cycle clear: applies
        step(1'b1, chbit(0, 3), 1'b0, '0, 1'b0);      // slot before the write
        wr(8'h01, 1'b1);                              // not seen by the slot above
        step(1'b1, chbit(0, 3), 1'b0, '0, 1'b0);      // seen here
        idle(4);
        // R2/R4: majority-of-three condition, then a back-to-back stream (R5).
        for (int a = 0; a < (1 << NC); a++) wr(a[NC-1:0], $countones(a[NC-1:0]) >= 3);
        for (int i = 0; i < 60; i++) begin
            logic [NB-1:0] b;
            b = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) b = b & {$urandom, $urandom, $urandom, $urandom};
            if (i % 7 == 0) step(1'b1, b, 1'b1, 8'($urandom), 1'($urandom));
            else            step(1'b1, b, 1'b0, '0, 1'b0);
        end
        idle(8);
        check(q.size() == 0, "R5", "all results delivered", 64'(q.size()), 64'd0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule